// File: doc/BRIEF.md
# Plug-and-Play I/O Window Decoder

This block keeps the configuration state of a single Plug-and-Play logical device on an ISA-style bus and decodes the I/O window assigned to it. Configuration software reaches four byte-wide registers through an index port and a data port: a write to the index port selects a register, and later data-port reads and writes act on it. The registers hold the device-enable bit, the range-check controls and a 16-bit I/O base address split into a high byte and a low byte. Data-port access works only while the configuration-state input is high. Because there is only one logical device, no device number has to be selected first.

On the bus side, the block compares address bits [11:3] with the same bits of the base. It asserts a device select in the same cycle as a matching I/O read or write strobe, but only while the device is enabled. While the device is disabled and range checking is on, reads that land in the window get a fixed answer: 55h or AAh, picked by a pattern bit. This lets software confirm that the window it chose is free of other decoders. The serial isolation protocol, card numbering and resource ROM are handled elsewhere.

Top module: `isa_pnp_iodec`

## Requirements
- R1: After reset, the enable register (index 30h) and the range-check register (index 31h) read 00h, and the base registers read 0000h.
- R2: A write to the index port selects the register used by later data-port accesses. Indices other than 30h, 31h, 60h and 61h ignore writes and read as 00h.
- R3: While the configuration-state input is low, data-port writes leave every register unchanged and `cfg_rdata` reads 00h. `cfg_rdata` is also 00h whenever no data-port read is in progress.
- R4: Index 30h holds the enable bit in bit 0. Bits [7:1] always read 0.
- R5: Index 31h holds the range-check enable in bit 1 and the pattern select in bit 0. Bits [7:2] always read 0.
- R6: Index 60h holds base address bits [15:8] and index 61h holds bits [7:0]. All bits read back as written.
- R7: While enabled, `dev_sel` is high in the same cycle as `bus_ior` or `bus_iow` when `bus_addr[11:3]` equals `base[11:3]`. Address bits [15:12] and [2:0] do not affect the match.
- R8: While disabled, `dev_sel` stays low for every bus cycle.
- R9: While disabled with range checking on, an I/O read that hits the window raises `rc_drive` in the same cycle. `rc_data` is then 55h when the pattern bit is 1 and AAh when it is 0. At all other times `rc_data` is 00h.
- R10: `rc_drive` stays low when the device is enabled, when range checking is off, for I/O writes, and for addresses outside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | High while the card is in the configuration state |
| cfg_idx_wr | input | 1 | Index-port write strobe |
| cfg_dat_wr | input | 1 | Data-port write strobe |
| cfg_dat_rd | input | 1 | Data-port read strobe |
| cfg_wdata | input | 8 | Write data for the index and data ports |
| cfg_rdata | output | 8 | Data-port read value, 00h when not reading |
| bus_addr | input | 16 | Bus I/O address |
| bus_ior | input | 1 | I/O read strobe |
| bus_iow | input | 1 | I/O write strobe |
| dev_sel | output | 1 | Device select for a window hit while enabled |
| rc_drive | output | 1 | High while the range-check pattern is being returned |
| rc_data | output | 8 | Range-check pattern, 00h when not driving |

## Verification
Any stored bit that is wrong is visible within one data-port read after the register is selected, because each register reads back through `cfg_rdata` with its reserved bits forced to zero. A wrong enable or range-check bit, or a wrong base bit in [11:3], shows up on `dev_sel`, `rc_drive` or `rc_data` in the same cycle as the next bus strobe aimed at the window, since the decode path has no registers. A corrupted index register shows up on the next data-port read as the value of some other register, or as 00h.

// File: rtl/pnp_dec_pkg.sv
package pnp_dec_pkg;
   localparam logic [7:0] IDX_ENABLE  = 8'h30;
   localparam logic [7:0] IDX_RCHECK  = 8'h31;
   localparam logic [7:0] IDX_BASE_HI = 8'h60;
   localparam logic [7:0] IDX_BASE_LO = 8'h61;

   typedef struct packed {
      logic enable;
      logic rc_en;
      logic rc_pat;
   } dev_ctl_t;
endpackage

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
   import pnp_dec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              idx_wr,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output dev_ctl_t          ctl,
   output logic [ADDR_W-1:0] base
);
   localparam int HALF = ADDR_W / 2;

   logic [DATA_W-1:0] idx_q;
   logic [HALF-1:0]   base_hi_q, base_lo_q;
   dev_ctl_t          ctl_q;
   logic              wr_ok, rd_ok;

   assign wr_ok = cfg_mode & dat_wr;
   assign rd_ok = cfg_mode & dat_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (idx_wr) begin
         idx_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         base_hi_q <= '0;
         base_lo_q <= '0;
      end else if (wr_ok) begin
         unique case (idx_q)
            IDX_ENABLE:  ctl_q.enable <= wdata[0];
            IDX_RCHECK:  begin
               ctl_q.rc_en  <= wdata[1];
               ctl_q.rc_pat <= wdata[0];
            end
            IDX_BASE_HI: base_hi_q <= wdata[HALF-1:0];
            IDX_BASE_LO: base_lo_q <= wdata[HALF-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_ok) begin
         unique case (idx_q)
            IDX_ENABLE:  rdata[0]   = ctl_q.enable;
            IDX_RCHECK:  rdata[1:0] = {ctl_q.rc_en, ctl_q.rc_pat};
            IDX_BASE_HI: rdata[HALF-1:0] = base_hi_q;
            IDX_BASE_LO: rdata[HALF-1:0] = base_lo_q;
            default:     rdata = '0;
         endcase
      end
   end

   assign ctl  = ctl_q;
   assign base = {base_hi_q, base_lo_q};
endmodule

// File: rtl/pnp_win_cmp.sv
module pnp_win_cmp #(
   parameter int DEC_W   = 12,
   parameter int WIN_LG2 = 3
) (
   input  logic [DEC_W-1:WIN_LG2] addr_cmp,
   input  logic [DEC_W-1:WIN_LG2] base_cmp,
   output logic                   hit
);
   localparam int CMP_W = DEC_W - WIN_LG2;

   logic [CMP_W-1:0] eq_bit;

   for (genvar i = 0; i < CMP_W; i++) begin : g_eq
      assign eq_bit[i] = ~(addr_cmp[WIN_LG2+i] ^ base_cmp[WIN_LG2+i]);
   end

   assign hit = &eq_bit;
endmodule

// File: rtl/pnp_rc_resp.sv
module pnp_rc_resp #(
   parameter int DATA_W = 8
) (
   input  logic              rc_en,
   input  logic              rc_pat,
   input  logic              enable,
   input  logic              hit,
   input  logic              ior,
   output logic              drive,
   output logic [DATA_W-1:0] data
);
   localparam logic [DATA_W-1:0] PAT_ONE  = {(DATA_W/2){2'b01}};
   localparam logic [DATA_W-1:0] PAT_ZERO = {(DATA_W/2){2'b10}};

   assign drive = rc_en & ~enable & hit & ior;
   assign data  = drive ? (rc_pat ? PAT_ONE : PAT_ZERO) : '0;
endmodule

// File: rtl/isa_pnp_iodec.sv
module isa_pnp_iodec
   import pnp_dec_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 16,
   parameter int DEC_W   = 12,
   parameter int WIN_LG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              cfg_idx_wr,
   input  logic              cfg_dat_wr,
   input  logic              cfg_dat_rd,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_ior,
   input  logic              bus_iow,
   output logic              dev_sel,
   output logic              rc_drive,
   output logic [DATA_W-1:0] rc_data
);
   if (DATA_W != 8) begin : g_bad_data
      $error("DATA_W must be 8");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
      $error("ADDR_W must be twice DATA_W");
   end
   if (DEC_W > ADDR_W || WIN_LG2 < 1 || WIN_LG2 >= DEC_W) begin : g_bad_dec
      $error("need 1 <= WIN_LG2 < DEC_W <= ADDR_W");
   end

   dev_ctl_t          ctl;
   logic [ADDR_W-1:0] base;
   logic              hit;
   logic              unused_bits;

   pnp_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_mode(cfg_mode),
      .idx_wr (cfg_idx_wr),
      .dat_wr (cfg_dat_wr),
      .dat_rd (cfg_dat_rd),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .ctl    (ctl),
      .base   (base)
   );

   pnp_win_cmp #(.DEC_W(DEC_W), .WIN_LG2(WIN_LG2)) u_cmp (
      .addr_cmp(bus_addr[DEC_W-1:WIN_LG2]),
      .base_cmp(base[DEC_W-1:WIN_LG2]),
      .hit     (hit)
   );

   pnp_rc_resp #(.DATA_W(DATA_W)) u_rc (
      .rc_en (ctl.rc_en),
      .rc_pat(ctl.rc_pat),
      .enable(ctl.enable),
      .hit   (hit),
      .ior   (bus_ior),
      .drive (rc_drive),
      .data  (rc_data)
   );

   assign dev_sel = ctl.enable & hit & (bus_ior | bus_iow);

   if (DEC_W < ADDR_W) begin : g_hi_ignored
      assign unused_bits = &{1'b0, bus_addr[ADDR_W-1:DEC_W], base[ADDR_W-1:DEC_W],
                             bus_addr[WIN_LG2-1:0], base[WIN_LG2-1:0]};
   end else begin : g_full
      assign unused_bits = &{1'b0, bus_addr[WIN_LG2-1:0], base[WIN_LG2-1:0]};
   end
endmodule

// File: rtl/isa_pnp_iodec_chk.sv
module isa_pnp_iodec_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_mode,
   input logic              cfg_dat_rd,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic              bus_ior,
   input logic              bus_iow,
   input logic              dev_sel,
   input logic              rc_drive,
   input logic [DATA_W-1:0] rc_data
);
   AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      dev_sel |-> (bus_ior | bus_iow)); // R7
   AST_SEL_RC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_sel && rc_drive)); // R10
   AST_RC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rc_drive |-> bus_ior); // R10
   AST_RC_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      rc_drive |-> (rc_data == 8'h55 || rc_data == 8'hAA)); // R9
   AST_RC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rc_drive |-> (rc_data == '0)); // R9
   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_mode && cfg_dat_rd) |-> (cfg_rdata == '0)); // R3
endmodule

bind isa_pnp_iodec isa_pnp_iodec_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_mode  (cfg_mode),
   .cfg_dat_rd(cfg_dat_rd),
   .cfg_rdata (cfg_rdata),
   .bus_ior   (bus_ior),
   .bus_iow   (bus_iow),
   .dev_sel   (dev_sel),
   .rc_drive  (rc_drive),
   .rc_data   (rc_data)
);

// File: tb/isa_pnp_iodec_tb.sv
module isa_pnp_iodec_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_mode = 1'b1;
   logic       cfg_idx_wr = 1'b0, cfg_dat_wr = 1'b0, cfg_dat_rd = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic [15:0] bus_addr = '0;
   logic       bus_ior = 1'b0, bus_iow = 1'b0;
   logic       dev_sel, rc_drive;
   logic [7:0] rc_data;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   isa_pnp_iodec u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .cfg_idx_wr(cfg_idx_wr), .cfg_dat_wr(cfg_dat_wr), .cfg_dat_rd(cfg_dat_rd),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .bus_addr(bus_addr), .bus_ior(bus_ior), .bus_iow(bus_iow),
      .dev_sel(dev_sel), .rc_drive(rc_drive), .rc_data(rc_data)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_index(input logic [7:0] idx);
      @(negedge clk);
      cfg_idx_wr = 1'b1; cfg_wdata = idx;
      @(negedge clk);
      cfg_idx_wr = 1'b0;
   endtask

   task automatic reg_wr(input logic [7:0] idx, input logic [7:0] val);
      set_index(idx);
      cfg_dat_wr = 1'b1; cfg_wdata = val;
      @(negedge clk);
      cfg_dat_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] idx, output logic [7:0] val);
      set_index(idx);
      cfg_dat_rd = 1'b1;
      #1 val = cfg_rdata;
      @(negedge clk);
      cfg_dat_rd = 1'b0;
   endtask

   task automatic bus_cyc(input logic [15:0] a, input logic rd, input logic wr,
                          output logic sel, output logic drv, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_ior = rd; bus_iow = wr;
      #1 sel = dev_sel; drv = rc_drive; d = rc_data;
      @(negedge clk);
      bus_ior = 1'b0; bus_iow = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v; logic s, dr; logic [7:0] d;
      reg_rd(8'h30, v); check("R1 enable after reset", {8'h0, v}, 16'h0000);
      reg_rd(8'h31, v); check("R1 rcheck after reset", {8'h0, v}, 16'h0000);
      reg_rd(8'h60, v); check("R1 base hi after reset", {8'h0, v}, 16'h0000);
      reg_rd(8'h61, v); check("R1 base lo after reset", {8'h0, v}, 16'h0000);
      bus_cyc(16'h0000, 1'b1, 1'b0, s, dr, d);
      check("R8 no select after reset", {15'h0, s}, 16'h0000);
   endtask

   task automatic t_regs();
      logic [7:0] v;
      reg_wr(8'h60, 8'hA5); reg_wr(8'h61, 8'h3C);
      reg_rd(8'h60, v); check("R6 base hi readback", {8'h0, v}, 16'h00A5);
      reg_rd(8'h61, v); check("R6 base lo readback", {8'h0, v}, 16'h003C);
      reg_wr(8'h30, 8'hFF);
      reg_rd(8'h30, v); check("R4 enable reserved bits", {8'h0, v}, 16'h0001);
      reg_wr(8'h30, 8'hFE);
      reg_rd(8'h30, v); check("R4 enable cleared", {8'h0, v}, 16'h0000);
      reg_wr(8'h31, 8'hFF);
      reg_rd(8'h31, v); check("R5 rcheck reserved bits", {8'h0, v}, 16'h0003);
      reg_wr(8'h31, 8'hFE);
      reg_rd(8'h31, v); check("R5 rcheck pattern bit", {8'h0, v}, 16'h0002);
      reg_wr(8'h31, 8'h00);
      reg_wr(8'h45, 8'hFF);
      reg_rd(8'h45, v); check("R2 unimplemented index", {8'h0, v}, 16'h0000);
      reg_rd(8'h60, v); check("R2 other index untouched", {8'h0, v}, 16'h00A5);
   endtask

   task automatic t_nocfg();
      logic [7:0] v;
      set_index(8'h60);
      cfg_mode = 1'b0;
      cfg_dat_wr = 1'b1; cfg_wdata = 8'h11;
      @(negedge clk);
      cfg_dat_wr = 1'b0;
      cfg_dat_rd = 1'b1;
      #1 check("R3 read outside config", {8'h0, cfg_rdata}, 16'h0000);
      @(negedge clk);
      cfg_dat_rd = 1'b0;
      cfg_mode = 1'b1;
      #1 check("R3 idle read value", {8'h0, cfg_rdata}, 16'h0000);
      reg_rd(8'h60, v); check("R3 write outside config ignored", {8'h0, v}, 16'h00A5);
   endtask

   task automatic t_decode();
      logic s, dr; logic [7:0] d;
      reg_wr(8'h60, 8'hA5); reg_wr(8'h61, 8'h38); reg_wr(8'h30, 8'h01);
      bus_cyc(16'hA538, 1'b1, 1'b0, s, dr, d); check("R7 read hit", {15'h0, s}, 16'h0001);
      bus_cyc(16'h5538, 1'b1, 1'b0, s, dr, d); check("R7 upper nibble ignored", {15'h0, s}, 16'h0001);
      bus_cyc(16'hA53F, 1'b0, 1'b1, s, dr, d); check("R7 write hit top of window", {15'h0, s}, 16'h0001);
      bus_cyc(16'hA540, 1'b1, 1'b0, s, dr, d); check("R7 above window", {15'h0, s}, 16'h0000);
      bus_cyc(16'hA537, 1'b1, 1'b0, s, dr, d); check("R7 below window", {15'h0, s}, 16'h0000);
      bus_cyc(16'hA538, 1'b0, 1'b0, s, dr, d); check("R7 no strobe", {15'h0, s}, 16'h0000);
      bus_cyc(16'hA438, 1'b1, 1'b0, s, dr, d); check("R7 bit 8 differs", {15'h0, s}, 16'h0000);
   endtask

   task automatic t_inactive();
      logic s, dr; logic [7:0] d;
      reg_wr(8'h30, 8'h00);
      bus_cyc(16'hA538, 1'b1, 1'b0, s, dr, d); check("R8 disabled read", {15'h0, s}, 16'h0000);
      bus_cyc(16'hA53A, 1'b0, 1'b1, s, dr, d); check("R8 disabled write", {15'h0, s}, 16'h0000);
   endtask

   task automatic t_rcheck();
      logic s, dr; logic [7:0] d;
      bus_cyc(16'hA538, 1'b1, 1'b0, s, dr, d);
      check("R10 range check off", {7'h0, dr, d}, 16'h0000);
      reg_wr(8'h31, 8'h03);
      bus_cyc(16'hA53C, 1'b1, 1'b0, s, dr, d);
      check("R9 pattern 55", {7'h0, dr, d}, 16'h0155);
      reg_wr(8'h31, 8'h02);
      bus_cyc(16'h6539, 1'b1, 1'b0, s, dr, d);
      check("R9 pattern AA", {7'h0, dr, d}, 16'h01AA);
      bus_cyc(16'hA53C, 1'b0, 1'b1, s, dr, d);
      check("R10 write not answered", {7'h0, dr, d}, 16'h0000);
      bus_cyc(16'hA540, 1'b1, 1'b0, s, dr, d);
      check("R10 miss not answered", {7'h0, dr, d}, 16'h0000);
      reg_wr(8'h30, 8'h01);
      bus_cyc(16'hA53C, 1'b1, 1'b0, s, dr, d);
      check("R10 enabled suppresses", {6'h0, s, dr, d}, 16'h0200);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_nocfg();
      t_decode();
      t_inactive();
      t_rcheck();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule